// File: doc/BRIEF.md
# Sorting Interrupt Controller

This block collects level-sensitive interrupt requests from `NUM_BANKS*32` sources (96 by default, 128 with four banks) and presents one winner at a time to a processor over a simple 32-bit register bus. Each source has a mask bit and a 6-bit priority. A source is eligible when it is high, unmasked and its priority passes the threshold filter. When any source is eligible, a fixed sorting window of `SORT_CYCLES` clock cycles starts. At the end of the window the chosen source number is latched into the sorted-result register and the interrupt line is raised.

If the chosen source drops during the window, or any mask register is written during it, the result is flagged spurious. In that case the upper bits of the sorted-result register read as all ones and the interrupt line stays low. Software acknowledges by writing the control register. This frees the controller to sort again, so a level that is still high re-interrupts.

A soft reset returns the programmable state to its defaults and reports completion through a status bit. A protection bit limits register access to privileged bus cycles.

Top module: `sort_intc`

## Requirements
- R1: After hardware reset every mask bit is 1, the threshold reads 0xFF, the sorted-result register (0x40) reads 0xFFFFFFFF, `irq_out` is 0 and status (0x14) bit 0 reads 1.
- R2: Mask register of bank n is at 0x84+0x20*n and is written directly. Writing to 0x88+0x20*n clears the mask bits where the data has ones. Writing to 0x8C+0x20*n sets them. Zero data bits leave the mask unchanged.
- R3: Reading 0x98+0x20*n returns the raw requests of bank n ANDed with the inverted mask bits.
- R4: `irq_out` rises exactly `SORT_CYCLES` clock edges after the first edge at which a source is eligible. The sorted-result register then holds the source number in bits [6:0] with bits [31:7] zero.
- R5: Source i has a level register at 0x100+4*i. Bits [7:2] hold a priority where 0 is highest, and bits [1:0] read 0. The lowest priority value wins, and ties go to the lowest source number.
- R6: A source is eligible only if its priority is below the low byte of the threshold register (0x68). A threshold of 0xFF passes every priority.
- R7: If the latched winner's request is low at any edge of the window, or any mask register (R2) is written at any edge of the window including the last, the result is spurious. Bits [31:7] then read all ones, bits [6:0] hold the number, and `irq_out` stays 0.
- R8: Writing 1 to bit 0 of the control register (0x48) while a result is held clears `irq_out` and sets the sorted-result register to 0xFFFFFFFF. A new sort may start at the next edge.
- R9: Writing 1 to bit 1 of the system configuration register (0x10) restores the R1 state, abandons any sort and clears all priorities. Status bit 0 reads 0 for `RST_CYCLES` edges and then 1, and register writes are ignored meanwhile. Configuration bit 1 always reads 0.
- R10: While protection (0x4C bit 0) is 1, a bus access with `bus_priv`=0 writes nothing and reads 0. The protection register itself is written only with `bus_priv`=1.
- R11: Address 0x00 reads `{REV_MAJOR, REV_MINOR}` in bits [7:0]. Idle register (0x50) bits [1:0] and configuration bit 0 (autoidle) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level interrupt requests |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the address |
| irq_out | output | 1 | Valid unacknowledged winner held |

## Verification
The sensitive coincidence is a mask register write landing on the final edge of the sorting window, the same edge that latches the result. The bench raises a source, waits until exactly one window edge remains, and then issues a mask-set write to an unrelated bank. It expects the spurious pattern with the source number, and no interrupt. A second coincidence is a soft reset issued while a valid result is held. There the bench expects the interrupt to drop and the result register to read all ones at the very next sample.

// File: rtl/sort_intc_pkg.sv
package sort_intc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_HOLD = 2'd2
    } sort_st_e;

    localparam int unsigned PRIO_W  = 6;
    localparam int unsigned NUM_W   = 7;
    localparam int unsigned BANK_W  = 32;

    localparam int unsigned OFS_REV   = 32'h000;
    localparam int unsigned OFS_SYSC  = 32'h010;
    localparam int unsigned OFS_STAT  = 32'h014;
    localparam int unsigned OFS_SIR   = 32'h040;
    localparam int unsigned OFS_CTRL  = 32'h048;
    localparam int unsigned OFS_PROT  = 32'h04C;
    localparam int unsigned OFS_IDLE  = 32'h050;
    localparam int unsigned OFS_THR   = 32'h068;
    localparam int unsigned OFS_MIR0  = 32'h084;
    localparam int unsigned OFS_MCLR0 = 32'h088;
    localparam int unsigned OFS_MSET0 = 32'h08C;
    localparam int unsigned OFS_PEND0 = 32'h098;
    localparam int unsigned BANK_STEP = 32'h020;
    localparam int unsigned OFS_LVL0  = 32'h100;

endpackage

// File: rtl/sort_intc_mbank.sv
module sort_intc_mbank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_clr,
    input  logic        wr_dir,
    input  logic        wr_clr,
    input  logic        wr_set,
    input  logic [31:0] wdata,
    output logic [31:0] mask_o
);

    logic [31:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_dir)      mask_d = wdata;
        else if (wr_clr) mask_d = mask_q & ~wdata;
        else if (wr_set) mask_d = mask_q | wdata;
        if (soft_clr)    mask_d = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !soft_clr) |=> ((mask_o & $past(wdata)) == '0));
    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !soft_clr) |=> ((mask_o & $past(wdata)) == $past(wdata)));

endmodule

// File: rtl/sort_intc_pick.sv
module sort_intc_pick
    import sort_intc_pkg::*;
#(
    parameter int unsigned NSRC = 96
) (
    input  logic [NSRC-1:0]        elig,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic                   found,
    output logic [NUM_W-1:0]       win
);

    logic [PRIO_W-1:0] best;

    // Strict less-than keeps the lowest index on equal priority (R5).
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
                found = 1'b1;
                win   = NUM_W'(i);
                best  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/sort_intc_seq.sv
module sort_intc_seq
    import sort_intc_pkg::*;
#(
    parameter int unsigned NSRC        = 96,
    parameter int unsigned SORT_CYCLES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             found,
    input  logic [NUM_W-1:0] win,
    input  logic [NSRC-1:0]  src,
    input  logic             mask_evt,
    input  logic             ack,
    output logic             irq_o,
    output logic [31:0]      sir_o
);

    localparam int unsigned CNT_W = $clog2(SORT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SORT_CYCLES - 1);

    typedef struct packed {
        sort_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] num;
        logic             spur;
        logic [31:0]      sir;
    } seq_t;

    function automatic seq_t seq_init();
        seq_t s;
        s     = '0;
        s.st  = ST_IDLE;
        s.sir = '1;
        return s;
    endfunction

    seq_t r_d, r_q;
    logic spur_nxt;

    always_comb begin
        r_d      = r_q;
        spur_nxt = r_q.spur | mask_evt | !src[r_q.num];
        case (r_q.st)
            ST_IDLE: begin
                if (found) begin
                    r_d.st   = ST_SORT;
                    r_d.cnt  = CNT_W'(1);
                    r_d.num  = win;
                    r_d.spur = mask_evt;
                end
            end
            ST_SORT: begin
                r_d.spur = spur_nxt;
                if (r_q.cnt == CNT_LAST) begin
                    r_d.st  = ST_HOLD;
                    r_d.sir = spur_nxt ? {25'h1FF_FFFF, r_q.num} : {25'h0, r_q.num};
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (ack) begin
                    r_d      = seq_init();
                end
            end
            default: r_d = seq_init();
        endcase
        if (soft_clr) r_d = seq_init();
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= seq_init();
        else        r_q <= r_d;
    end

    assign irq_o = (r_q.st == ST_HOLD) && !r_q.spur;
    assign sir_o = r_q.sir;

    assert_rise_after_sort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(r_q.st == ST_SORT));
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SORT) |-> (r_q.cnt != '0 && r_q.cnt <= CNT_LAST));
    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && ack && !soft_clr) |=> (r_q.st == ST_IDLE && !irq_o));
    assert_drop_spur_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SORT && !src[r_q.num] && !soft_clr) |=> r_q.spur);

endmodule

// File: rtl/sort_intc.sv
module sort_intc
    import sort_intc_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 3,
    parameter int unsigned SORT_CYCLES = 10,
    parameter int unsigned RST_CYCLES  = 4,
    parameter int unsigned ADDR_W      = 10,
    parameter logic [3:0]  REV_MAJOR   = 4'h5,
    parameter logic [3:0]  REV_MINOR   = 4'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BANKS*32-1:0]   irq_src,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic                      bus_priv,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq_out
);

    localparam int unsigned NSRC = NUM_BANKS * BANK_W;
    localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);

    localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_SYSC = ADDR_W'(OFS_SYSC);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SIR  = ADDR_W'(OFS_SIR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(OFS_PROT);
    localparam logic [ADDR_W-1:0] A_IDLE = ADDR_W'(OFS_IDLE);
    localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);

    typedef struct packed {
        logic                          auto_idle;
        logic                          prot;
        logic [1:0]                    idle;
        logic [7:0]                    thr;
        logic [RC_W-1:0]               rcnt;
        logic [NSRC-1:0][PRIO_W-1:0]   prio;
    } cfg_t;

    function automatic cfg_t cfg_init();
        cfg_t c;
        c     = '0;
        c.thr = 8'hFF;
        return c;
    endfunction

    cfg_t cfg_d, cfg_q;

    logic                       wr_req, busy, wr_ok, soft_go, ack, mask_evt;
    logic [NUM_BANKS-1:0]       wr_dir, wr_clr, wr_set;
    logic [NUM_BANKS-1:0][31:0] mask, pend;
    logic [NSRC-1:0]            mask_flat, thr_pass, elig;
    logic                       found;
    logic [NUM_W-1:0]           win;
    logic [31:0]                sir_w, rd;

    assign wr_req   = bus_sel & bus_wr;
    assign busy     = (cfg_q.rcnt != '0);
    assign wr_ok    = wr_req & !busy & (!cfg_q.prot | bus_priv);
    assign soft_go  = wr_ok && (bus_addr == A_SYSC) && bus_wdata[1];
    assign ack      = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
    assign mask_evt = |{wr_dir, wr_clr, wr_set};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_dir[b] = wr_ok && (bus_addr == ADDR_W'(OFS_MIR0  + BANK_STEP*b));
        assign wr_clr[b] = wr_ok && (bus_addr == ADDR_W'(OFS_MCLR0 + BANK_STEP*b));
        assign wr_set[b] = wr_ok && (bus_addr == ADDR_W'(OFS_MSET0 + BANK_STEP*b));

        sort_intc_mbank u_mbank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_go),
            .wr_dir   (wr_dir[b]),
            .wr_clr   (wr_clr[b]),
            .wr_set   (wr_set[b]),
            .wdata    (bus_wdata),
            .mask_o   (mask[b])
        );

        assign pend[b] = irq_src[b*BANK_W +: BANK_W] & ~mask[b];
    end

    assign mask_flat = mask;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            thr_pass[i] = (cfg_q.thr == 8'hFF) || ({2'b00, cfg_q.prio[i]} < cfg_q.thr);
            elig[i]     = irq_src[i] & ~mask_flat[i] & thr_pass[i];
        end
    end

    sort_intc_pick #(.NSRC(NSRC)) u_pick (
        .elig      (elig),
        .prio_flat (cfg_q.prio),
        .found     (found),
        .win       (win)
    );

    sort_intc_seq #(.NSRC(NSRC), .SORT_CYCLES(SORT_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_go),
        .found    (found),
        .win      (win),
        .src      (irq_src),
        .mask_evt (mask_evt),
        .ack      (ack),
        .irq_o    (irq_out),
        .sir_o    (sir_w)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (busy) cfg_d.rcnt = cfg_q.rcnt - 1'b1;
        if (wr_ok) begin
            if (bus_addr == A_SYSC)             cfg_d.auto_idle = bus_wdata[0];
            if (bus_addr == A_PROT && bus_priv) cfg_d.prot      = bus_wdata[0];
            if (bus_addr == A_IDLE)             cfg_d.idle      = bus_wdata[1:0];
            if (bus_addr == A_THR)              cfg_d.thr       = bus_wdata[7:0];
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == ADDR_W'(OFS_LVL0 + 4*i)) cfg_d.prio[i] = bus_wdata[7:2];
            end
        end
        if (soft_go) begin
            cfg_d      = cfg_init();
            cfg_d.rcnt = RC_W'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_init();
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd = '0;
        if      (bus_addr == A_REV)  rd = {24'h0, REV_MAJOR, REV_MINOR};
        else if (bus_addr == A_SYSC) rd = {31'h0, cfg_q.auto_idle};
        else if (bus_addr == A_STAT) rd = {31'h0, !busy};
        else if (bus_addr == A_SIR)  rd = sir_w;
        else if (bus_addr == A_PROT) rd = {31'h0, cfg_q.prot};
        else if (bus_addr == A_IDLE) rd = {30'h0, cfg_q.idle};
        else if (bus_addr == A_THR)  rd = {24'h0, cfg_q.thr};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFS_MIR0  + BANK_STEP*b)) rd = mask[b];
            if (bus_addr == ADDR_W'(OFS_PEND0 + BANK_STEP*b)) rd = pend[b];
        end
        for (int i = 0; i < NSRC; i++) begin
            if (bus_addr == ADDR_W'(OFS_LVL0 + 4*i)) rd = {24'h0, cfg_q.prio[i], 2'b00};
        end
        if (!bus_sel || (cfg_q.prot && !bus_priv)) rd = '0;
    end

    assign bus_rdata = rd;

    assert_irq_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (sir_w[31:7] == '0));
    assert_soft_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_go |=> (!irq_out && sir_w == '1 && busy));
    assert_prot_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.prot && wr_req && !bus_priv) |=> $stable(cfg_q.thr));

endmodule

// File: tb/sort_intc_tb.sv
module sort_intc_tb;

    localparam int CLK_P  = 10;
    localparam int NB     = 3;
    localparam int NSRC   = NB * 32;
    localparam int NSORT  = 10;
    localparam int NRST   = 4;

    localparam logic [9:0] A_REV  = 10'h000;
    localparam logic [9:0] A_SYSC = 10'h010;
    localparam logic [9:0] A_STAT = 10'h014;
    localparam logic [9:0] A_SIR  = 10'h040;
    localparam logic [9:0] A_CTRL = 10'h048;
    localparam logic [9:0] A_PROT = 10'h04C;
    localparam logic [9:0] A_IDLE = 10'h050;
    localparam logic [9:0] A_THR  = 10'h068;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [9:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    sort_intc #(.NUM_BANKS(NB), .SORT_CYCLES(NSORT), .RST_CYCLES(NRST)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [9:0] mir(input int b);  return 10'(32'h84 + 32*b); endfunction
    function automatic logic [9:0] mclr(input int b); return 10'(32'h88 + 32*b); endfunction
    function automatic logic [9:0] mset(input int b); return 10'(32'h8C + 32*b); endfunction
    function automatic logic [9:0] pend(input int b); return 10'(32'h98 + 32*b); endfunction
    function automatic logic [9:0] lvl(input int i);  return 10'(32'h100 + 4*i); endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic rd(input logic [9:0] a, input logic pv, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = pv;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic pv);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = pv;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic chk_rd(input string tag, input logic [9:0] a, input logic pv, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, pv, v);
        check(tag, v, exp);
    endtask

    // Scoreboard: driver side records the expected sorted result.
    task automatic sb_push(input logic [31:0] v);
        exp_q.push_back(v);
    endtask

    // Monitor side: pops the oldest expectation and compares the design's result.
    task automatic sb_pop(input string tag);
        logic [31:0] v;
        rd(A_SIR, 1'b1, v);
        if (exp_q.size() == 0) check({tag, " (empty queue)"}, v, 32'hDEAD_BEEF);
        else                   check(tag, v, exp_q.pop_front());
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        check(tag, {31'h0, irq_out}, {31'h0, exp});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1 sir", A_SIR, 1'b1, 32'hFFFF_FFFF);
        chk_rd("R1 mask", mir(0), 1'b1, 32'hFFFF_FFFF);
        chk_rd("R1 thr", A_THR, 1'b1, 32'h0000_00FF);
        chk_rd("R1 status", A_STAT, 1'b1, 32'h1);
        chk_irq("R1 irq", 1'b0);

        // R11 identity and plain storage
        chk_rd("R11 rev", A_REV, 1'b1, 32'h50);
        wr(A_IDLE, 32'h3, 1'b1);
        chk_rd("R11 idle", A_IDLE, 1'b1, 32'h3);
        wr(A_SYSC, 32'h1, 1'b1);
        chk_rd("R11 autoidle", A_SYSC, 1'b1, 32'h1);

        // R2 mask aliases
        wr(mclr(0), 32'h0000_00FF, 1'b1);
        chk_rd("R2 clear alias", mir(0), 1'b1, 32'hFFFF_FF00);
        wr(mset(0), 32'h0000_0001, 1'b1);
        chk_rd("R2 set alias", mir(0), 1'b1, 32'hFFFF_FF01);
        wr(mir(0), 32'h0, 1'b1);
        wr(mir(1), 32'h0000_0100, 1'b1);
        wr(mir(2), 32'h0, 1'b1);
        chk_rd("R2 direct", mir(1), 1'b1, 32'h0000_0100);

        // R3 masked pending, then R4 window length
        irq_src[40] = 1'b1;
        chk_rd("R3 pending masked", pend(1), 1'b1, 32'h0);
        wr(mclr(1), 32'h0000_0100, 1'b1);
        chk_rd("R3 pending open", pend(1), 1'b1, 32'h0000_0100);
        step(NSORT - 1);
        chk_irq("R4 irq before window end", 1'b0);
        step(1);
        chk_irq("R4 irq at window end", 1'b1);
        sb_push(32'd40);
        sb_pop("R4 sorted number");

        // R8 ack with level still high re-sorts
        wr(A_CTRL, 32'h1, 1'b1);
        chk_irq("R8 irq after ack", 1'b0);
        chk_rd("R8 sir after ack", A_SIR, 1'b1, 32'hFFFF_FFFF);
        step(NSORT - 1);
        chk_irq("R8 no early re-sort", 1'b0);
        step(1);
        chk_irq("R8 re-sort", 1'b1);
        sb_push(32'd40);
        sb_pop("R8 re-sort number");
        irq_src[40] = 1'b0;
        wr(A_CTRL, 32'h1, 1'b1);

        // R5 priority and ties
        wr(lvl(3), 32'h17, 1'b1);
        chk_rd("R5 level readback", lvl(3), 1'b1, 32'h14);
        wr(lvl(40), 32'h08, 1'b1);
        irq_src[3] = 1'b1; irq_src[40] = 1'b1;
        step(NSORT);
        sb_push(32'd40);
        sb_pop("R5 priority winner");
        irq_src[3] = 1'b0; irq_src[40] = 1'b0;
        wr(A_CTRL, 32'h1, 1'b1);
        irq_src[10] = 1'b1; irq_src[20] = 1'b1;
        step(NSORT);
        sb_push(32'd10);
        sb_pop("R5 tie lowest index");
        irq_src[10] = 1'b0; irq_src[20] = 1'b0;
        wr(A_CTRL, 32'h1, 1'b1);

        // R6 threshold filter
        wr(A_THR, 32'h5, 1'b1);
        irq_src[3] = 1'b1;
        step(NSORT + 2);
        chk_irq("R6 filtered no irq", 1'b0);
        chk_rd("R6 filtered sir", A_SIR, 1'b1, 32'hFFFF_FFFF);
        wr(A_THR, 32'h6, 1'b1);
        step(NSORT - 1);
        chk_irq("R6 not yet", 1'b0);
        step(1);
        chk_irq("R6 passes", 1'b1);
        sb_push(32'd3);
        sb_pop("R6 winner");
        irq_src[3] = 1'b0;
        wr(A_CTRL, 32'h1, 1'b1);
        wr(A_THR, 32'hFF, 1'b1);

        // R7 winner drops inside window
        irq_src[5] = 1'b1;
        step(3);
        irq_src[5] = 1'b0;
        step(NSORT - 3);
        chk_irq("R7 drop no irq", 1'b0);
        sb_push(32'hFFFF_FF85);
        sb_pop("R7 drop spurious");
        wr(A_CTRL, 32'h1, 1'b1);

        // R7 mask write on the last window edge
        irq_src[7] = 1'b1;
        step(NSORT - 1);
        wr(mset(2), 32'h1, 1'b1);
        chk_irq("R7 mask no irq", 1'b0);
        sb_push(32'hFFFF_FF87);
        sb_pop("R7 mask spurious");
        irq_src[7] = 1'b0;
        wr(A_CTRL, 32'h1, 1'b1);

        // R9 soft reset while holding a valid result
        irq_src[33] = 1'b1;
        step(NSORT);
        chk_irq("R9 pre irq", 1'b1);
        wr(A_SYSC, 32'h2, 1'b1);
        chk_irq("R9 irq cleared", 1'b0);
        chk_rd("R9 sir cleared", A_SIR, 1'b1, 32'hFFFF_FFFF);
        chk_rd("R9 status busy", A_STAT, 1'b1, 32'h0);
        step(NRST - 1);
        chk_rd("R9 status still busy", A_STAT, 1'b1, 32'h0);
        step(1);
        chk_rd("R9 status done", A_STAT, 1'b1, 32'h1);
        chk_rd("R9 mask", mir(1), 1'b1, 32'hFFFF_FFFF);
        chk_rd("R9 thr", A_THR, 1'b1, 32'hFF);
        chk_rd("R9 level", lvl(3), 1'b1, 32'h0);
        chk_rd("R9 sysconfig", A_SYSC, 1'b1, 32'h0);
        irq_src[33] = 1'b0;

        // R10 protection
        wr(A_PROT, 32'h1, 1'b1);
        wr(A_THR, 32'h10, 1'b0);
        chk_rd("R10 user read", A_THR, 1'b0, 32'h0);
        chk_rd("R10 user write ignored", A_THR, 1'b1, 32'hFF);
        wr(A_PROT, 32'h0, 1'b1);
        chk_rd("R10 unprotected read", A_THR, 1'b0, 32'hFF);

        finish_run();
    end

endmodule